// File: doc/BRIEF.md
# SPI Command and Payload Buffer Slave

This block is the serial front end of an accelerator. It acts as an SPI mode-0 slave (clock idles low, data sampled on the rising edge). An external master opens a transaction by pulling chip select low. It then sends one command byte followed by a fixed number of payload bytes, set by a parameter. The block stores the command, places each payload byte in an input buffer, and raises a busy flag and then a sending flag. From the byte slot right after the last payload byte, it streams the contents of an output buffer back on MISO. The accelerator loads the output buffer through a simple write port.

Bit shifting runs on the external SCK. Buffers, flags and indices run on the system clock. Each finished byte crosses between the two domains on a toggle flag and a two-flop synchronizer, so that exactly one write happens per byte. The system clock must run at least four times as fast as SCK. Chip select must stay high for at least four system clock cycles between transactions.

Top module: `spi_cmd_buffer`

## Requirements
- R1: While `cs_n` is high, `miso` is 0, and the serial bit counter and shift registers are cleared, so every transaction starts on a byte boundary.
- R2: MOSI is sampled on each SCK rising edge, most significant bit first, and a byte is complete after 8 rising edges.
- R3: Byte slot 0 of a transaction is the command. It appears on `cmd_code` and sets `busy`.
- R4: Byte slots 1 to PAYLOAD_LEN are written in order to payload entries 0 to PAYLOAD_LEN-1. Entry i occupies bits [8*i+7 : 8*i] of `payload`.
- R5: `sending` is set once slot PAYLOAD_LEN (the last payload byte) has been received, and never before. `sending` implies `busy`.
- R6: MISO changes only on SCK falling edges and sends bytes MSB first. Slot PAYLOAD_LEN+1+k carries output buffer entry k, for k from 0 to PAYLOAD_LEN-1.
- R7: Every slot with no output buffer entry carries 0x00. This covers the command and payload slots and all slots after the output buffer is used up.
- R8: Bytes received after slot PAYLOAD_LEN leave the payload buffer unchanged.
- R9: A rising edge on `cs_n`, once synchronized, clears `busy`, `sending` and both indices. `cmd_code` and `payload` keep their values.
- R10: Each received byte produces exactly one write into the system clock domain, so no payload entry is skipped or written twice.
- R11: When `obuf_we` is high on a system clock edge, `obuf_data` is stored in output buffer entry `obuf_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock from master |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| obuf_we | input | 1 | Output buffer write enable |
| obuf_addr | input | ADDR_W | Output buffer entry to write |
| obuf_data | input | 8 | Output buffer write data |
| cmd_code | output | 8 | Last received command byte |
| payload | output | 8*PAYLOAD_LEN | Input buffer contents, entry 0 in the low byte |
| busy | output | 1 | Command received in this transaction |
| sending | output | 1 | Full payload received, response streaming |

## Verification
The bench clocks extra bytes past the end of the response. A design that kept writing would corrupt the payload buffer, and one that failed to stop at the end of the output buffer would return stale data instead of zeros. A short transaction ends before the payload is complete. It shows whether `sending` rises too early and whether chip select clears the flags without wiping the buffers. One run uses the minimum 4:1 clock ratio. A crossing that loses or repeats a byte pulse would shift payload entries, and a late response byte would leave the first response slot off by one.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic busy;
        logic send;
    } flags_t;

    function automatic byte_t shift_in(input byte_t cur, input logic b);
        return {cur[BYTE_W-2:0], b};
    endfunction

    function automatic byte_t shift_out(input byte_t cur);
        return {cur[BYTE_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/spi_bit_sync.sv
module spi_bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_sck_shifter.sv
module spi_sck_shifter
    import spi_cmd_pkg::*;
(
    input  logic  sclk,
    input  logic  cs_n,
    input  logic  rst,
    input  logic  mosi,
    input  byte_t tx_next,
    output logic  miso,
    output byte_t rx_byte,
    output logic  done_tgl
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);
    localparam logic [BIT_CNT_W-1:0] MID_BIT  = BIT_CNT_W'(BYTE_W / 2 - 1);

    logic [BIT_CNT_W-1:0] bit_cnt;
    byte_t rx_sh, tx_hold, tx_sh, rx_q;
    logic  miso_q, tgl_q;

    // Rising edge: sample MOSI, count bits, take the next response byte mid-byte
    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_hold <= '0;
        end else begin
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
            rx_sh   <= shift_in(rx_sh, mosi);
            if (bit_cnt == MID_BIT) tx_hold <= tx_next;
        end
    end

    // Completed byte and its toggle survive chip select
    always_ff @(posedge sclk or posedge rst) begin
        if (rst) begin
            rx_q  <= '0;
            tgl_q <= 1'b0;
        end else if (!cs_n && bit_cnt == LAST_BIT) begin
            rx_q  <= shift_in(rx_sh, mosi);
            tgl_q <= ~tgl_q;
        end
    end

    // Falling edge: present the next bit on MISO
    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            tx_sh  <= '0;
            miso_q <= 1'b0;
        end else if (bit_cnt == '0) begin
            miso_q <= tx_hold[BYTE_W-1];
            tx_sh  <= shift_out(tx_hold);
        end else begin
            miso_q <= tx_sh[BYTE_W-1];
            tx_sh  <= shift_out(tx_sh);
        end
    end

    assign miso     = miso_q & ~cs_n;
    assign rx_byte  = rx_q;
    assign done_tgl = tgl_q;
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spi_cmd_pkg::*;
#(
    parameter  int PAYLOAD_LEN = 4,
    localparam int ADDR_W = (PAYLOAD_LEN > 1) ? $clog2(PAYLOAD_LEN) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cs_rise,
    input  logic                          byte_pulse,
    input  byte_t                         rx_byte,
    input  logic                          ob_we,
    input  logic [ADDR_W-1:0]             ob_addr,
    input  byte_t                         ob_wdata,
    output byte_t                         tx_next,
    output byte_t                         cmd_out,
    output flags_t                        flags,
    output logic [PAYLOAD_LEN*BYTE_W-1:0] in_flat
);
    localparam int                CNT_W    = $clog2(PAYLOAD_LEN + 2);
    localparam int                IDX_W    = $clog2(PAYLOAD_LEN + 1);
    localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(PAYLOAD_LEN + 1);
    localparam int                PREP_AT  = PAYLOAD_LEN - 1;

    logic [CNT_W-1:0] cnt;      // byte slot index, doubles as write index
    logic [IDX_W-1:0] rd_idx;   // next output entry to hand to the shifter
    flags_t           flags_q;
    byte_t            cmd_q, tx_q;
    byte_t            in_mem  [PAYLOAD_LEN];
    byte_t            out_mem [PAYLOAD_LEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            rd_idx  <= '0;
            flags_q <= '0;
            cmd_q   <= '0;
            tx_q    <= '0;
        end else begin
            if (byte_pulse) begin
                if (cnt == '0) begin
                    cmd_q        <= rx_byte;
                    flags_q.busy <= 1'b1;
                end
                if (cnt == CNT_W'(PAYLOAD_LEN)) flags_q.send <= 1'b1;
                if (cnt != LAST_CNT) cnt <= cnt + 1'b1;
                // value prepared now goes out two slots later
                if (int'(cnt) >= PREP_AT) begin
                    if (int'(rd_idx) < PAYLOAD_LEN) begin
                        tx_q   <= out_mem[rd_idx[ADDR_W-1:0]];
                        rd_idx <= rd_idx + 1'b1;
                    end else begin
                        tx_q <= '0;
                    end
                end
            end
            if (cs_rise) begin
                cnt     <= '0;
                rd_idx  <= '0;
                flags_q <= '0;
                tx_q    <= '0;
            end
        end
    end

    for (genvar i = 0; i < PAYLOAD_LEN; i++) begin : g_buf
        always_ff @(posedge clk) begin
            if (rst)
                in_mem[i] <= '0;
            else if (byte_pulse && cnt == CNT_W'(i + 1))
                in_mem[i] <= rx_byte;
        end
        always_ff @(posedge clk) begin
            if (rst)
                out_mem[i] <= '0;
            else if (ob_we && ob_addr == ADDR_W'(i))
                out_mem[i] <= ob_wdata;
        end
        assign in_flat[i*BYTE_W +: BYTE_W] = in_mem[i];
    end

    assign tx_next = tx_q;
    assign cmd_out = cmd_q;
    assign flags   = flags_q;

    // R10: the crossing never yields two byte writes on consecutive cycles
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        byte_pulse |=> !byte_pulse);

    // R5: streaming never starts without a command
    assert_send_needs_busy_R5: assert property (@(posedge clk) disable iff (rst)
        flags_q.send |-> flags_q.busy);

    // R9: chip select release clears flags and indices
    assert_cs_clear_R9: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> (flags_q == '0 && cnt == '0 && rd_idx == '0));

    // R3: busy only rises on a received byte
    assert_busy_from_byte_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.busy) |-> $past(byte_pulse));

    // R8: bytes past the payload leave the input buffer alone
    assert_extra_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (byte_pulse && cnt == LAST_CNT) |=> $stable(in_flat));

    // R7: read index never runs past the output buffer
    assert_rd_bound_R7: assert property (@(posedge clk) disable iff (rst)
        int'(rd_idx) <= PAYLOAD_LEN);
endmodule

// File: rtl/spi_cmd_buffer.sv
module spi_cmd_buffer
    import spi_cmd_pkg::*;
#(
    parameter  int PAYLOAD_LEN = 4,
    localparam int ADDR_W = (PAYLOAD_LEN > 1) ? $clog2(PAYLOAD_LEN) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sclk,
    input  logic                     cs_n,
    input  logic                     mosi,
    output logic                     miso,
    input  logic                     obuf_we,
    input  logic [ADDR_W-1:0]        obuf_addr,
    input  logic [7:0]               obuf_data,
    output logic [7:0]               cmd_code,
    output logic [PAYLOAD_LEN*8-1:0] payload,
    output logic                     busy,
    output logic                     sending
);
    byte_t  rx_byte, tx_next;
    logic   done_tgl, tgl_s, tgl_prev, cs_s, cs_prev;
    logic   cs_rise, byte_pulse;
    flags_t flags;

    spi_sck_shifter u_shift (
        .sclk     (sclk),
        .cs_n     (cs_n),
        .rst      (rst),
        .mosi     (mosi),
        .tx_next  (tx_next),
        .miso     (miso),
        .rx_byte  (rx_byte),
        .done_tgl (done_tgl)
    );

    spi_bit_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_tgl (
        .clk (clk), .rst (rst), .d (done_tgl), .q (tgl_s)
    );

    spi_bit_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_cs (
        .clk (clk), .rst (rst), .d (cs_n), .q (cs_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tgl_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            tgl_prev <= tgl_s;
            cs_prev  <= cs_s;
        end
    end

    assign byte_pulse = tgl_s ^ tgl_prev;
    assign cs_rise    = cs_s & ~cs_prev;

    spi_cmd_ctrl #(.PAYLOAD_LEN(PAYLOAD_LEN)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cs_rise    (cs_rise),
        .byte_pulse (byte_pulse),
        .rx_byte    (rx_byte),
        .ob_we      (obuf_we),
        .ob_addr    (obuf_addr),
        .ob_wdata   (obuf_data),
        .tx_next    (tx_next),
        .cmd_out    (cmd_code),
        .flags      (flags),
        .in_flat    (payload)
    );

    assign busy    = flags.busy;
    assign sending = flags.send;
endmodule

// File: tb/spi_cmd_buffer_test.sv
`timescale 1ns/1ps
module spi_cmd_buffer_test;
    localparam int N  = 4;
    localparam int AW = 2;

    logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, obuf_we = 1'b0, busy, sending;
    logic [AW-1:0] obuf_addr = '0;
    logic [7:0] obuf_data = '0, cmd_code;
    logic [N*8-1:0] payload;

    int n_chk = 0, n_fail = 0, cs_hi = 0, half_ns = 20;
    logic [7:0] m_in [N];
    logic [7:0] m_out [N];

    spi_cmd_buffer #(.PAYLOAD_LEN(N)) uut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .obuf_we(obuf_we), .obuf_addr(obuf_addr), .obuf_data(obuf_data),
        .cmd_code(cmd_code), .payload(payload), .busy(busy), .sending(sending)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock reference checks on idle behaviour
    always @(negedge clk) begin
        if (!rst) begin
            if (cs_n) begin
                chk(miso == 1'b0, "R1 miso idle", 64'(miso), 0);
                cs_hi++;
                if (cs_hi > 6) chk(!busy && !sending, "R9 flags cleared", {busy, sending}, 0);
            end else cs_hi = 0;
        end
    end

    task automatic load_out(input int a, input logic [7:0] d);
        @(negedge clk);
        obuf_we = 1'b1; obuf_addr = AW'(a); obuf_data = d;
        @(negedge clk);
        obuf_we = 1'b0;
        m_out[a] = d;
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            #(half_ns);
            rx[i] = miso;
            sclk = 1'b1;
            #(half_ns);
            sclk = 1'b0;
        end
    endtask

    function automatic logic [7:0] exp_slot(input int j);
        if (j >= N + 1 && j - N - 1 < N) return m_out[j - N - 1];
        return 8'h00;
    endfunction

    task automatic xact(input logic [7:0] q[$], input string name);
        logic [7:0] rx;
        cs_n = 1'b0;
        #(half_ns);
        for (int j = 0; j < q.size(); j++) begin
            spi_byte(q[j], rx);
            // R6 / R7: response byte in each slot, MSB first
            if (exp_slot(j) != 8'h00)
                chk(rx == exp_slot(j), {"R6 response ", name}, rx, exp_slot(j));
            else
                chk(rx == 8'h00, {"R7 zero slot ", name}, rx, 0);
            #30;
            if (j == 0) chk(busy == 1'b1, {"R3 busy after command ", name}, busy, 1);
            if (j < N)  chk(sending == 1'b0, {"R5 no early send ", name}, sending, 0);
            if (j == N) chk(sending == 1'b1, {"R5 send after payload ", name}, sending, 1);
            if (j == 0) begin
                chk(cmd_code == q[0], {"R3 command code ", name}, cmd_code, q[0]);
            end else if (j <= N) begin
                m_in[j-1] = q[j];
            end
        end
        #(half_ns);
        cs_n = 1'b1;
        #100;
        chk(!busy && !sending, {"R9 clear on release ", name}, {busy, sending}, 0);
        chk(cmd_code == q[0], {"R9 command kept ", name}, cmd_code, q[0]);
        for (int i = 0; i < N; i++)
            chk(payload[i*8 +: 8] == m_in[i], {"R4 R8 R10 payload entry ", name},
                payload[i*8 +: 8], m_in[i]);
    endtask

    initial begin
        logic [7:0] q[$];
        for (int i = 0; i < N; i++) begin m_in[i] = 8'h00; m_out[i] = 8'h00; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_code == 8'h00 && !busy && !sending, "R1 reset state", {cmd_code, busy, sending}, 0);
        chk(payload == '0, "R1 reset payload", 64'(payload), 0);

        // R11: load output buffer through the port
        load_out(0, 8'hA1); load_out(1, 8'hB2); load_out(2, 8'hC3); load_out(3, 8'hD4);

        // R2 R8: standard traffic plus clocking past the response
        q = {8'h02, 8'h55, 8'h55, 8'h55, 8'h55, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        xact(q, "std");

        // R4: distinct payload order
        q = {8'h7E, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'h00, 8'h00, 8'h00};
        xact(q, "order");

        // short transaction: send never raised, tail entries kept
        q = {8'h13, 8'h9A, 8'hBC};
        xact(q, "short");

        // R11 reload, R2 at the minimum 4:1 clock ratio
        load_out(0, 8'h0F); load_out(1, 8'h80); load_out(2, 8'h01); load_out(3, 8'hFE);
        half_ns = 10;
        q = {8'hC5, 8'h5A, 8'hA5, 8'h3C, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        xact(q, "fast");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule